// File: doc/BRIEF.md
# Software-Refilled Set-Associative Translation Buffer

This block translates virtual pages to physical pages for a core that has no hardware page walker. Each lookup presents a virtual address and an address-space identifier. The block searches only the ways of the one set that the address selects, all of them in parallel. One cycle later it reports a hit with the physical page number and permission bits, or it reports a miss. A miss is the request for the exception handler. The faulting virtual address is kept in a register so the handler can read it.

The contents change in only two ways. The first is a load command that carries one entry as two 64-bit words. Hardware picks the set from the entry's virtual page. The entry is pushed into way 0 of that set, the older ways move down by one, and the last way drops out. The second is a global invalidate input, which clears every valid bit. Software cannot read entries and cannot choose a way. To remove a page, it loads invalid entries for that address until the set has turned over.

The response logic is a three-state machine. RSP_IDLE means no lookup was presented in the previous cycle. RSP_HIT means the previous lookup matched. RSP_MISS means the previous lookup did not match. From any state, the machine goes to RSP_IDLE when no lookup is presented, to RSP_HIT when a presented lookup matches, and to RSP_MISS when it does not.

Top module: `soft_tlb`

## Requirements
- R1: Entry encoding and indexing. The low word carries the virtual address in bits 47:0, and its bits 13:0 and 63:48 are ignored. The high word carries the valid bit at 63, the global bit at 62, the permissions at 59:56, the ASID at 55:40 and the physical page number at 35:0. Pages are 16 KiB, so the set index is address bits 21:14 and the virtual page number is bits 47:14.
- R2: A response appears exactly one cycle after each cycle in which `lkp_valid_i` is high. `rsp_valid_o` is low in every other cycle.
- R3: A lookup hits when a way of its set is valid, holds an equal virtual page number, and either holds an equal ASID or has its global bit set. On a hit the stored page number and permissions are returned. Both read zero when the response is not a hit.
- R4: A lookup that does not hit raises `miss_o` for exactly its response cycle, together with `rsp_valid_o`. In that cycle `rsp_hit_o` is low.
- R5: `fault_va_o` is zero after reset. It captures the full lookup address in the cycle `miss_o` is high, and it keeps its value in all other cycles.
- R6: A load puts the new entry in way 0 of its set and moves each older way down by one. The oldest way is discarded. When several ways match, the most recently loaded one wins.
- R7: After 4 (WAYS) loads of invalid entries into a set, every entry that was in that set before them misses.
- R8: A lookup in the same cycle as a load or a flush sees the contents as they were before that cycle. The change is visible to lookups from the next cycle.
- R9: `flush_i` clears every valid bit in one cycle, just as reset does. A load issued in the same cycle as a flush is discarded.
- R10: A load changes no entry in any set other than the one its address selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Clear all valid bits |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_va_i | input | 48 | Lookup virtual address |
| lkp_asid_i | input | 16 | Lookup address-space ID |
| load_i | input | 1 | Load-entry command |
| load_hi_i | input | 64 | Entry high word (flags, ASID, page number) |
| load_lo_i | input | 64 | Entry low word (virtual address) |
| rsp_valid_o | output | 1 | Lookup response present |
| rsp_hit_o | output | 1 | Response is a hit |
| rsp_ppn_o | output | 36 | Physical page number on hit |
| rsp_perm_o | output | 4 | Permission bits on hit |
| miss_o | output | 1 | Miss exception request |
| fault_va_o | output | 48 | Address of the last missing lookup |

## Verification
The hardest situations to reach from the ports are those in which a set is full of entries whose outcome depends on age. Examples are two live entries for the same page, which must resolve to the newest, and a set that must be fully flushed out by invalid loads. Random addresses are drawn from three sets, three tags and two ASIDs, so that sets fill, overflow and collide within a few cycles. Directed sequences add the cases that need exact timing: a duplicate load, a lookup in the same cycle as a load or flush, a flush in the same cycle as a load, and a turnover by four invalid loads that leaves a neighbouring set untouched.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
    localparam int VA_W       = 48;
    localparam int PAGE_SHIFT = 14;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int ASID_W     = 16;
    localparam int PPN_W      = 36;
    localparam int PERM_W     = 4;
    localparam int WORD_W     = 64;

    localparam int HI_VALID    = 63;
    localparam int HI_GLOBAL   = 62;
    localparam int HI_PERM_LSB = 56;
    localparam int HI_ASID_LSB = 40;
    localparam int HI_PPN_LSB  = 0;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } tlb_entry_t;

    function automatic tlb_entry_t unpack_entry(input logic [WORD_W-1:0] hi,
                                                input logic [WORD_W-1:0] lo);
        tlb_entry_t e;
        e.vpn  = lo[VA_W-1:PAGE_SHIFT];
        e.asid = hi[HI_ASID_LSB +: ASID_W];
        e.glob = hi[HI_GLOBAL];
        e.ppn  = hi[HI_PPN_LSB +: PPN_W];
        e.perm = hi[HI_PERM_LSB +: PERM_W];
        return e;
    endfunction
endpackage

// File: rtl/soft_tlb_store.sv
module soft_tlb_store
    import soft_tlb_pkg::*;
#(
    parameter int SETS = 256,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             ld_en_i,
    input  logic [IDX_W-1:0] ld_idx_i,
    input  logic             ld_valid_i,
    input  tlb_entry_t       ld_entry_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [WAYS-1:0]  rd_valid_o,
    output tlb_entry_t       rd_entry_o [WAYS]
);
    logic [SETS-1:0][WAYS-1:0] valid_q;
    tlb_entry_t                ent_q [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush_i) begin
            valid_q <= '0;
        end else if (ld_en_i) begin
            for (int w = WAYS - 1; w > 0; w--) begin
                valid_q[ld_idx_i][w] <= valid_q[ld_idx_i][w-1];
            end
            valid_q[ld_idx_i][0] <= ld_valid_i;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_en_i && !flush_i) begin
            for (int w = WAYS - 1; w > 0; w--) begin
                ent_q[ld_idx_i][w] <= ent_q[ld_idx_i][w-1];
            end
            ent_q[ld_idx_i][0] <= ld_entry_i;
        end
    end

    assign rd_valid_o = valid_q[rd_idx_i];

    for (genvar g = 0; g < WAYS; g++) begin : g_rd
        assign rd_entry_o[g] = ent_q[rd_idx_i][g];
    end

    // R6
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en_i && !flush_i) |=> (valid_q[$past(ld_idx_i)][0] == $past(ld_valid_i)));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_q == '0));
endmodule

// File: rtl/soft_tlb_match.sv
module soft_tlb_match
    import soft_tlb_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  logic [VPN_W-1:0]  vpn_i,
    input  logic [ASID_W-1:0] asid_i,
    input  logic [WAYS-1:0]   way_valid_i,
    input  tlb_entry_t        way_entry_i [WAYS],
    output logic              hit_o,
    output logic [PPN_W-1:0]  ppn_o,
    output logic [PERM_W-1:0] perm_o
);
    logic [WAYS-1:0] way_hit;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign way_hit[g] = way_valid_i[g]
                          && (way_entry_i[g].vpn == vpn_i)
                          && (way_entry_i[g].glob || (way_entry_i[g].asid == asid_i));
    end

    always_comb begin
        hit_o  = 1'b0;
        ppn_o  = '0;
        perm_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                hit_o  = 1'b1;
                ppn_o  = way_entry_i[w].ppn;
                perm_o = way_entry_i[w].perm;
            end
        end
    end
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import soft_tlb_pkg::*;
#(
    parameter int SETS = 256,
    parameter int WAYS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              lkp_valid_i,
    input  logic [47:0]       lkp_va_i,
    input  logic [15:0]       lkp_asid_i,
    input  logic              load_i,
    input  logic [63:0]       load_hi_i,
    input  logic [63:0]       load_lo_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [35:0]       rsp_ppn_o,
    output logic [3:0]        rsp_perm_o,
    output logic              miss_o,
    output logic [47:0]       fault_va_o
);
    localparam int IDX_W = $clog2(SETS);

    typedef enum logic [1:0] {RSP_IDLE, RSP_HIT, RSP_MISS} rsp_state_e;

    rsp_state_e        state_q, state_d;
    logic [WAYS-1:0]   rd_valid;
    tlb_entry_t        rd_entry [WAYS];
    logic              m_hit;
    logic [PPN_W-1:0]  m_ppn, ppn_q;
    logic [PERM_W-1:0] m_perm, perm_q;
    logic [VA_W-1:0]   fault_q;
    logic              unused_bits;

    assign unused_bits = ^{load_hi_i[61:60], load_hi_i[39:36],
                           load_lo_i[63:48], load_lo_i[13:0]};

    soft_tlb_store #(.SETS(SETS), .WAYS(WAYS)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .ld_en_i    (load_i),
        .ld_idx_i   (load_lo_i[PAGE_SHIFT +: IDX_W]),
        .ld_valid_i (load_hi_i[HI_VALID]),
        .ld_entry_i (unpack_entry(load_hi_i, load_lo_i)),
        .rd_idx_i   (lkp_va_i[PAGE_SHIFT +: IDX_W]),
        .rd_valid_o (rd_valid),
        .rd_entry_o (rd_entry)
    );

    soft_tlb_match #(.WAYS(WAYS)) match_i (
        .vpn_i       (lkp_va_i[VA_W-1:PAGE_SHIFT]),
        .asid_i      (lkp_asid_i),
        .way_valid_i (rd_valid),
        .way_entry_i (rd_entry),
        .hit_o       (m_hit),
        .ppn_o       (m_ppn),
        .perm_o      (m_perm)
    );

    always_comb begin
        if (!lkp_valid_i) begin
            state_d = RSP_IDLE;
        end else if (m_hit) begin
            state_d = RSP_HIT;
        end else begin
            state_d = RSP_MISS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            ppn_q   <= '0;
            perm_q  <= '0;
            fault_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == RSP_HIT) begin
                ppn_q  <= m_ppn;
                perm_q <= m_perm;
            end
            if (state_d == RSP_MISS) begin
                fault_q <= lkp_va_i;
            end
        end
    end

    always_comb begin
        rsp_valid_o = 1'b0;
        rsp_hit_o   = 1'b0;
        rsp_ppn_o   = '0;
        rsp_perm_o  = '0;
        miss_o      = 1'b0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_HIT: begin
                rsp_valid_o = 1'b1;
                rsp_hit_o   = 1'b1;
                rsp_ppn_o   = ppn_q;
                rsp_perm_o  = perm_q;
            end
            RSP_MISS: begin
                rsp_valid_o = 1'b1;
                miss_o      = 1'b1;
            end
            default: ;
        endcase
    end

    assign fault_va_o = fault_q;

    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid_i |=> rsp_valid_o);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid_i |=> (!rsp_valid_o && !miss_o));

    // R5
    fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> (fault_va_o == $past(lkp_va_i)));

    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_o |-> $stable(fault_va_o));
endmodule

// File: tb/soft_tlb_tb_top.sv
module soft_tlb_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 256;
    localparam int WAYS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        lkp_valid_i = 1'b0;
    logic [47:0] lkp_va_i = '0;
    logic [15:0] lkp_asid_i = '0;
    logic        load_i = 1'b0;
    logic [63:0] load_hi_i = '0;
    logic [63:0] load_lo_i = '0;
    logic        rsp_valid_o, rsp_hit_o, miss_o;
    logic [35:0] rsp_ppn_o;
    logic [3:0]  rsp_perm_o;
    logic [47:0] fault_va_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    bit          m_valid [SETS][WAYS];
    logic [33:0] m_vpn   [SETS][WAYS];
    logic [15:0] m_asid  [SETS][WAYS];
    bit          m_glob  [SETS][WAYS];
    logic [35:0] m_ppn   [SETS][WAYS];
    logic [3:0]  m_perm  [SETS][WAYS];
    logic [47:0] m_fault = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    soft_tlb #(.SETS(SETS), .WAYS(WAYS)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .lkp_valid_i(lkp_valid_i), .lkp_va_i(lkp_va_i), .lkp_asid_i(lkp_asid_i),
        .load_i(load_i), .load_hi_i(load_hi_i), .load_lo_i(load_lo_i),
        .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_ppn_o(rsp_ppn_o),
        .rsp_perm_o(rsp_perm_o), .miss_o(miss_o), .fault_va_o(fault_va_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1: high word layout
    function automatic logic [63:0] mk_hi(bit v, bit g, logic [3:0] perm, logic [15:0] asid, logic [35:0] ppn);
        logic [63:0] h = '0;
        h[63] = v; h[62] = g; h[59:56] = perm; h[55:40] = asid; h[35:0] = ppn;
        return h;
    endfunction

    // R1: set index is address bits 21:14, upper tag bits 47:22
    function automatic logic [47:0] mk_va(logic [25:0] tag, logic [7:0] idx, logic [13:0] off);
        return {tag, idx, off};
    endfunction

    // R3/R6: newest matching way wins
    task automatic predict(input logic [47:0] va, input logic [15:0] asid,
                           output bit hit, output logic [35:0] ppn, output logic [3:0] perm);
        int s = int'(va[21:14]);
        hit = 1'b0; ppn = '0; perm = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (m_valid[s][w] && m_vpn[s][w] == va[47:14] && (m_glob[s][w] || m_asid[s][w] == asid)) begin
                hit = 1'b1; ppn = m_ppn[s][w]; perm = m_perm[s][w];
            end
        end
    endtask

    task automatic model_flush();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_valid[s][w] = 1'b0;
    endtask

    task automatic model_load(input logic [63:0] hi, input logic [63:0] lo);
        int s = int'(lo[21:14]);
        for (int w = WAYS - 1; w > 0; w--) begin
            m_valid[s][w] = m_valid[s][w-1]; m_vpn[s][w] = m_vpn[s][w-1];
            m_asid[s][w] = m_asid[s][w-1]; m_glob[s][w] = m_glob[s][w-1];
            m_ppn[s][w] = m_ppn[s][w-1]; m_perm[s][w] = m_perm[s][w-1];
        end
        m_valid[s][0] = hi[63]; m_glob[s][0] = hi[62]; m_perm[s][0] = hi[59:56];
        m_asid[s][0] = hi[55:40]; m_ppn[s][0] = hi[35:0]; m_vpn[s][0] = lo[47:14];
    endtask

    // One cycle, entered and left at a falling edge. R8: prediction precedes the update.
    task automatic step(input bit ld, input logic [63:0] hi, input logic [63:0] lo,
                        input bit lk, input logic [47:0] va, input logic [15:0] asid,
                        input bit fl, input string req);
        bit e_hit;
        logic [35:0] e_ppn;
        logic [3:0] e_perm;
        load_i = ld; load_hi_i = hi; load_lo_i = lo;
        lkp_valid_i = lk; lkp_va_i = va; lkp_asid_i = asid; flush_i = fl;
        predict(va, asid, e_hit, e_ppn, e_perm);
        if (!lk) e_hit = 1'b0;
        if (lk && !e_hit) m_fault = va;
        if (fl) model_flush();
        else if (ld) model_load(hi, lo);
        @(posedge clk);
        #1;
        chk(rsp_valid_o == lk, {"R2 ", req}, 64'(rsp_valid_o), 64'(lk));
        chk(rsp_hit_o == e_hit, {"R3 ", req}, 64'(rsp_hit_o), 64'(e_hit));
        chk(miss_o == (lk && !e_hit), {"R4 ", req}, 64'(miss_o), 64'(lk && !e_hit));
        chk(rsp_ppn_o == (e_hit ? e_ppn : 36'd0), {"R3 ppn ", req}, 64'(rsp_ppn_o), 64'(e_hit ? e_ppn : 36'd0));
        chk(rsp_perm_o == (e_hit ? e_perm : 4'd0), {"R3 perm ", req}, 64'(rsp_perm_o), 64'(e_hit ? e_perm : 4'd0));
        chk(fault_va_o == m_fault, {"R5 ", req}, 64'(fault_va_o), 64'(m_fault));
        @(negedge clk);
    endtask

    task automatic lookup(input logic [47:0] va, input logic [15:0] asid, input string req);
        step(1'b0, '0, '0, 1'b1, va, asid, 1'b0, req);
    endtask

    task automatic load(input logic [63:0] hi, input logic [47:0] va, input string req);
        step(1'b1, hi, {16'hdead, va}, 1'b0, '0, '0, 1'b0, req);
    endtask

    function automatic logic [47:0] rand_va();
        logic [7:0] sets [3] = '{8'd3, 8'd77, 8'd200};
        logic [25:0] tags [3] = '{26'h0000011, 26'h1abcdef, 26'h3000002};
        return mk_va(tags[$urandom % 3], sets[$urandom % 3], 14'($urandom));
    endfunction

    initial begin
        logic [47:0] va_a, va_b, va_c, va_d, va_far;
        void'($urandom(32'd20240517));
        model_flush();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5, R2: reset state
        chk(rsp_valid_o == 1'b0 && miss_o == 1'b0, "R2 reset outputs", 64'(rsp_valid_o), 64'd0);
        chk(fault_va_o == 48'd0, "R5 reset fault address", 64'(fault_va_o), 64'd0);

        va_a = mk_va(26'h0000aa, 8'd5, 14'h123);
        va_b = mk_va(26'h0000bb, 8'd5, 14'h000);
        va_c = mk_va(26'h0000cc, 8'd5, 14'h3ff);
        va_d = mk_va(26'h0000dd, 8'd9, 14'h010);
        va_far = mk_va(26'h0000ee, 8'd6, 14'h000);

        // R3: ASID match, mismatch, global
        load(mk_hi(1, 0, 4'h5, 16'd1, 36'h111), va_a, "R1 load A");
        lookup(va_a, 16'd1, "R3 asid match");
        lookup(va_a, 16'd2, "R3 asid mismatch");
        load(mk_hi(1, 1, 4'h3, 16'd7, 36'h222), va_b, "R1 load global B");
        lookup(va_b, 16'd9, "R3 global any asid");
        load(mk_hi(1, 0, 4'h1, 16'd1, 36'h444), va_far, "R10 load far set");
        // R8: same-cycle lookup and load sees old contents
        step(1'b1, mk_hi(1, 0, 4'h2, 16'd1, 36'h333), {16'h0, va_c}, 1'b1, va_c, 16'd1, 1'b0, "R8 same cycle");
        lookup(va_c, 16'd1, "R8 next cycle");
        // R6: duplicate load, newest wins
        load(mk_hi(1, 0, 4'h6, 16'd1, 36'h999), va_c, "R6 duplicate");
        lookup(va_c, 16'd1, "R6 newest wins");
        // R7: four invalid loads clear the set
        for (int i = 0; i < WAYS; i++) load(mk_hi(0, 0, 4'h0, 16'd0, 36'h0), va_c, "R7 invalid load");
        lookup(va_a, 16'd1, "R7 A evicted");
        lookup(va_b, 16'd1, "R7 B evicted");
        lookup(va_c, 16'd1, "R7 C evicted");
        lookup(va_far, 16'd1, "R10 other set kept");
        // R9: flush wins over a load in the same cycle
        load(mk_hi(1, 0, 4'h7, 16'd3, 36'h555), va_a, "R9 preload");
        step(1'b1, mk_hi(1, 0, 4'h8, 16'd3, 36'h666), {16'h0, va_d}, 1'b1, va_a, 16'd3, 1'b1, "R9 flush same cycle");
        lookup(va_d, 16'd3, "R9 load discarded");
        lookup(va_a, 16'd3, "R9 flushed");
        lookup(va_far, 16'd1, "R9 far flushed");
        step(1'b0, '0, '0, 1'b0, '0, '0, 1'b0, "R5 hold idle");

        // random mix over a small pool of sets, tags and ASIDs
        for (int i = 0; i < 3000; i++) begin
            bit ld = ($urandom % 2) == 0;
            bit lk = ($urandom % 10) < 7;
            bit fl = ($urandom % 64) == 0;
            logic [63:0] hi = mk_hi(($urandom % 5) != 0, ($urandom % 5) == 0, 4'($urandom),
                                    16'(1 + $urandom % 2), 36'($urandom));
            step(ld, hi, {16'($urandom), rand_va()}, lk, rand_va(), 16'(1 + $urandom % 2), fl, "R6 random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule